// File: doc/BRIEF.md
# Serial Engine Command Stream Decoder

This block sits behind a host byte link and turns a flat stream of opcodes and their trailing bytes into framed commands for a synchronous serial engine. Each incoming byte is accepted on a valid/ready handshake. The first byte of a frame is classified as a shift command or a control command. The block then works out how many header bytes follow and collects them. Once the header is complete it presents one descriptor. The descriptor holds the opcode, its shift flags, the transfer count and the packed header bytes.

Data bytes that belong to a shift command are not part of the descriptor. They leave on a separate payload stream, and the final byte is marked. Opcodes outside the defined set produce no descriptor and raise a sticky error flag. The byte after an unknown opcode is taken as a new opcode. Frames follow one another with no idle byte between them. Backpressure on either output stalls the input.

Top module: `cmd_stream_decoder`

## Requirements
- R1: After synchronous reset, `desc_valid`, `pay_valid` and `err_flag` are 0. `in_ready` is 1 while both output ready inputs are 1.
- R2: Control opcodes (bit 7 set) take this many header bytes:
  - 3 bytes: 0x93.
  - 2 bytes: 0x80, 0x82, 0x86, 0x8F, 0x91, 0x92, 0x9C, 0x9D and 0x9E.
  - 1 byte: 0x8E and 0x90.
  - No bytes: every other valid control opcode.
  The descriptor appears the cycle after the last header byte is accepted, or after the opcode when there are none. Header byte i sits in `desc_params[8i+7:8i]`, with unused bytes 0. `desc_nparam` gives the count.
- R3: For a shift opcode (bit 7 clear), `desc_shift` is 1 and `desc_flags` equals opcode bits 6..0. The flag bits are: bit 0 falling-edge launch, bit 1 bit mode, bit 2 falling-edge sample, bit 3 LSB first, bit 4 write data, bit 5 read data, bit 6 write mode-select line. For control opcodes `desc_shift`, `desc_flags` and `desc_count` are 0.
- R4: A byte-mode shift opcode (bit 1 = 0) takes a 2-byte little-endian length L, low byte first, and `desc_count` = L+1 (up to 65536). If bit 4 is set, exactly L+1 payload bytes follow; otherwise none.
- R5: A bit-mode shift opcode (bit 1 = 1) takes a 1-byte length L, and `desc_count` = L+1. One payload byte follows only when bit 4 or bit 6 is set.
- R6: The valid opcodes are 0x10–0x13, 0x18–0x1B, even 0x20–0x2E, 0x31, 0x33, 0x34, 0x36, 0x39, 0x3B, 0x3C, 0x3E, 0x4A, 0x4B, 0x6A, 0x6B, 0x6E, 0x6F, 0x80–0x97 and 0x9C–0x9E. Any other opcode emits no descriptor and sets `err_flag`, which stays set until reset. The next byte is decoded as an opcode.
- R7: While a descriptor or payload byte is held by a low ready, that output keeps its value and `in_ready` is 0. Consecutive frames are parsed with no gap bytes.
- R8: `pay_last` is 1 exactly on the final payload byte of a frame, and the payload bytes leave in arrival order.
- R9: A reset in the middle of a frame discards the partial header, and the next byte is decoded as an opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| desc_valid | output | 1 | Descriptor valid |
| desc_ready | input | 1 | Descriptor consumer ready |
| desc_opcode | output | 8 | Frame opcode |
| desc_shift | output | 1 | Opcode is a shift command |
| desc_flags | output | 7 | Shift flag bits, zero for control |
| desc_count | output | 17 | Transfer count in bytes or bits, zero for control |
| desc_nparam | output | 2 | Number of header bytes after the opcode |
| desc_params | output | 24 | Header bytes, first byte lowest |
| pay_valid | output | 1 | Payload byte valid |
| pay_ready | input | 1 | Payload consumer ready |
| pay_data | output | 8 | Payload byte |
| pay_last | output | 1 | Final payload byte of the frame |
| err_flag | output | 1 | Sticky unknown-opcode flag |

## Verification
A descriptor rises one clock after the edge that accepts its last header byte. A payload byte appears one clock after its own acceptance. `err_flag` sets one clock after an unknown opcode is taken. The bench drives inputs on the falling edge and samples the handshakes a few nanoseconds after it. Each handshake therefore counts in the same cycle the design sees it. Field checks run only after several idle cycles, once every registered result of the frame has settled.

The sweep sends all 256 opcodes, each with header and payload bytes computed from the opcode value. Directed cases then cover the length boundaries, the byte order of the count, a stall on each output, and a reset in mid-frame.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int CS_MAX_HDR = 3;
  localparam int CS_NP_W    = 2;

  typedef enum logic [1:0] {
    ST_OP  = 2'd0,
    ST_HDR = 2'd1,
    ST_PAY = 2'd2
  } parse_st_t;

  typedef struct packed {
    logic               known;
    logic               shift;
    logic               bitmode;
    logic               has_pay;
    logic [CS_NP_W-1:0] nhdr;
  } op_info_t;
endpackage

// File: rtl/cs_opcode_class.sv
module cs_opcode_class
  import cs_pkg::*;
(
  input  logic [7:0] op,
  output op_info_t   info
);
  logic known;
  logic [CS_NP_W-1:0] ctl_hdr;

  always_comb begin
    known = 1'b0;
    case (op[7:4])
      4'h1: known = ~op[2];
      4'h2: known = ~op[0];
      4'h3: known = op[0] ^ op[2];
      4'h4: known = (op[3:1] == 3'b101);
      4'h6: known = op[3] & op[1];
      4'h8: known = 1'b1;
      4'h9: known = (op[3:0] <= 4'h7) || ((op[3:0] >= 4'hC) && (op[3:0] <= 4'hE));
      default: known = 1'b0;
    endcase
  end

  always_comb begin
    case (op)
      8'h93: ctl_hdr = 2'd3;
      8'h80, 8'h82, 8'h86, 8'h8F, 8'h91, 8'h92,
      8'h9C, 8'h9D, 8'h9E: ctl_hdr = 2'd2;
      8'h8E, 8'h90: ctl_hdr = 2'd1;
      default: ctl_hdr = 2'd0;
    endcase
  end

  always_comb begin
    info.known   = known;
    info.shift   = ~op[7];
    info.bitmode = ~op[7] & op[1];
    info.has_pay = ~op[7] & (op[1] ? (op[4] | op[6]) : op[4]);
    info.nhdr    = op[7] ? ctl_hdr : (op[1] ? 2'd1 : 2'd2);
  end
endmodule

// File: rtl/cs_frame_parser.sv
module cs_frame_parser
  import cs_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int HMAX  = CS_MAX_HDR,
  localparam int PB_W  = 8 * HMAX,
  localparam int CNT_W = LEN_W + 1
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  input  op_info_t         info,
  output logic             desc_valid,
  input  logic             desc_ready,
  output logic [7:0]       desc_opcode,
  output logic             desc_shift,
  output logic [6:0]       desc_flags,
  output logic [CNT_W-1:0] desc_count,
  output logic [CS_NP_W-1:0] desc_nparam,
  output logic [PB_W-1:0]  desc_params,
  output logic             pay_valid,
  input  logic             pay_ready,
  output logic [7:0]       pay_data,
  output logic             pay_last,
  output logic             err_flag
);
  parse_st_t          state;
  op_info_t           info_q;
  logic [7:0]         op_q;
  logic [CS_NP_W-1:0] hidx;
  logic [PB_W-1:0]    hbuf, hbuf_n;
  logic [CNT_W-1:0]   pay_left, count_n, pay_total;
  logic               accept, hdr_done;

  assign in_ready = (~desc_valid | desc_ready) & (~pay_valid | pay_ready);
  assign accept   = in_valid & in_ready;
  assign hdr_done = (hidx == info_q.nhdr - 2'd1);

  always_comb begin
    hbuf_n = hbuf;
    for (int i = 0; i < HMAX; i++)
      if (hidx == CS_NP_W'(i)) hbuf_n[8*i +: 8] = in_data;
  end

  always_comb begin
    if (info_q.bitmode) count_n = CNT_W'(hbuf_n[7:0]) + CNT_W'(1);
    else                count_n = CNT_W'(hbuf_n[LEN_W-1:0]) + CNT_W'(1);
    if (!info_q.has_pay)    pay_total = '0;
    else if (info_q.bitmode) pay_total = CNT_W'(1);
    else                    pay_total = count_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_OP;  info_q <= '0;  op_q <= '0;
      hidx <= '0;  hbuf <= '0;  pay_left <= '0;
      desc_valid <= 1'b0;  desc_opcode <= '0;  desc_shift <= 1'b0;
      desc_flags <= '0;  desc_count <= '0;  desc_nparam <= '0;  desc_params <= '0;
      pay_valid <= 1'b0;  pay_data <= '0;  pay_last <= 1'b0;
      err_flag <= 1'b0;
    end else begin
      if (desc_valid && desc_ready) desc_valid <= 1'b0;
      if (pay_valid && pay_ready)   pay_valid  <= 1'b0;
      if (accept) begin
        case (state)
          ST_OP: begin
            op_q <= in_data;  info_q <= info;  hidx <= '0;  hbuf <= '0;
            if (!info.known) begin
              err_flag <= 1'b1;
            end else if (info.nhdr == '0) begin
              desc_valid  <= 1'b1;  desc_opcode <= in_data;
              desc_shift  <= 1'b0;  desc_flags  <= '0;
              desc_count  <= '0;    desc_nparam <= '0;  desc_params <= '0;
            end else begin
              state <= ST_HDR;
            end
          end
          ST_HDR: begin
            hbuf <= hbuf_n;
            hidx <= hidx + 2'd1;
            if (hdr_done) begin
              desc_valid  <= 1'b1;  desc_opcode <= op_q;
              desc_shift  <= info_q.shift;
              desc_flags  <= info_q.shift ? op_q[6:0] : 7'd0;
              desc_count  <= info_q.shift ? count_n : '0;
              desc_nparam <= info_q.nhdr;  desc_params <= hbuf_n;
              if (pay_total != '0) begin
                pay_left <= pay_total;
                state    <= ST_PAY;
              end else begin
                state <= ST_OP;
              end
            end
          end
          ST_PAY: begin
            pay_valid <= 1'b1;
            pay_data  <= in_data;
            pay_last  <= (pay_left == CNT_W'(1));
            pay_left  <= pay_left - CNT_W'(1);
            if (pay_left == CNT_W'(1)) state <= ST_OP;
          end
          default: state <= ST_OP;
        endcase
      end
    end
  end

  p_desc_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (desc_valid && !desc_ready) |=> (desc_valid && $stable(desc_opcode) && $stable(desc_params)));
  p_pay_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (pay_valid && !pay_ready) |=> (pay_valid && $stable(pay_data) && $stable(pay_last)));
  p_stall_r7: assert property (@(posedge clk) disable iff (rst)
    (desc_valid && !desc_ready) |-> !in_ready);
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag);
  p_ctl_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (desc_valid && !desc_shift) |-> (desc_flags == 7'd0 && desc_count == '0));
  p_last_ends_r8: assert property (@(posedge clk) disable iff (rst)
    (pay_valid && pay_ready && pay_last) |=> !pay_valid);
endmodule

// File: rtl/cmd_stream_decoder.sv
module cmd_stream_decoder
  import cs_pkg::*;
#(
  parameter int LEN_W = 16,
  localparam int PB_W  = 8 * CS_MAX_HDR,
  localparam int CNT_W = LEN_W + 1
)(
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [7:0]         in_data,
  output logic               in_ready,
  output logic               desc_valid,
  input  logic               desc_ready,
  output logic [7:0]         desc_opcode,
  output logic               desc_shift,
  output logic [6:0]         desc_flags,
  output logic [CNT_W-1:0]   desc_count,
  output logic [CS_NP_W-1:0] desc_nparam,
  output logic [PB_W-1:0]    desc_params,
  output logic               pay_valid,
  input  logic               pay_ready,
  output logic [7:0]         pay_data,
  output logic               pay_last,
  output logic               err_flag
);
  op_info_t info;

  cs_opcode_class u_class (
    .op   (in_data),
    .info (info)
  );

  cs_frame_parser #(.LEN_W(LEN_W), .HMAX(CS_MAX_HDR)) u_parser (
    .clk, .rst, .in_valid, .in_data, .in_ready,
    .info        (info),
    .desc_valid, .desc_ready, .desc_opcode, .desc_shift, .desc_flags,
    .desc_count, .desc_nparam, .desc_params,
    .pay_valid, .pay_ready, .pay_data, .pay_last, .err_flag
  );
endmodule

// File: tb/tb_cmd_stream_decoder.sv
`timescale 1ns/1ps
module tb_cmd_stream_decoder;
  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, desc_ready = 1'b1, pay_ready = 1'b1;
  logic [7:0] in_data = 8'h00;
  logic in_ready, desc_valid, desc_shift, pay_valid, pay_last, err_flag;
  logic [7:0] desc_opcode, pay_data;
  logic [6:0] desc_flags;
  logic [16:0] desc_count;
  logic [1:0] desc_nparam;
  logic [23:0] desc_params;

  always #10 clk = ~clk;

  cmd_stream_decoder dut (.*);

  int nchk = 0, nerr = 0;
  int ndesc = 0, npay = 0, nlast = 0, last_idx = 0;
  int psum = 0;
  logic [7:0] c_op, c_pdata; logic c_shift; logic [6:0] c_flags;
  logic [16:0] c_count; logic [1:0] c_np; logic [23:0] c_params;

  always @(negedge clk) begin
    #3;
    if (!rst) begin
      if (desc_valid && desc_ready) begin
        ndesc++; c_op = desc_opcode; c_shift = desc_shift; c_flags = desc_flags;
        c_count = desc_count; c_np = desc_nparam; c_params = desc_params;
      end
      if (pay_valid && pay_ready) begin
        npay++; psum += pay_data; c_pdata = pay_data;
        if (pay_last) begin nlast++; last_idx = npay; end
      end
    end
  end

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin nerr++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic send(input logic [7:0] b);
    in_valid = 1'b1; in_data = b; #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    in_valid = 1'b0; rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic logic m_known(input logic [7:0] op);
    if (op >= 8'h10 && op <= 8'h13) return 1;
    if (op >= 8'h18 && op <= 8'h1B) return 1;
    if (op >= 8'h20 && op <= 8'h2E && (op % 2 == 0)) return 1;
    if (op == 8'h31 || op == 8'h33 || op == 8'h34 || op == 8'h36) return 1;
    if (op == 8'h39 || op == 8'h3B || op == 8'h3C || op == 8'h3E) return 1;
    if (op == 8'h4A || op == 8'h4B || op == 8'h6A || op == 8'h6B) return 1;
    if (op == 8'h6E || op == 8'h6F) return 1;
    if (op >= 8'h80 && op <= 8'h97) return 1;
    return (op >= 8'h9C && op <= 8'h9E);
  endfunction

  function automatic int m_nhdr(input logic [7:0] op);
    if (op < 8'h80) return ((op / 2) % 2 == 1) ? 1 : 2;
    if (op == 8'h93) return 3;
    if (op == 8'h80 || op == 8'h82 || op == 8'h86 || op == 8'h8F || op == 8'h91 ||
        op == 8'h92 || op == 8'h9C || op == 8'h9D || op == 8'h9E) return 2;
    if (op == 8'h8E || op == 8'h90) return 1;
    return 0;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int d0, p0, s0, l0;
    do_reset();
    #1;
    check(!desc_valid && !pay_valid && !err_flag && in_ready, "R1 reset state",
          {desc_valid, pay_valid, err_flag, in_ready}, 4'b0001);

    for (int op = 0; op < 256; op++) begin
      logic [7:0] o; int nh, cnt, npl, esum; logic [23:0] eprm;
      o = op[7:0]; d0 = ndesc; p0 = npay; s0 = psum; l0 = nlast;
      nh = m_nhdr(o); eprm = 0; cnt = 0; npl = 0; esum = 0;
      send(o);
      if (m_known(o)) begin
        for (int i = 0; i < nh; i++) begin
          logic [7:0] b;
          if (o < 8'h80) b = (i == 0) ? ((nh == 1) ? (o % 8) : (o % 4)) : 8'h00;
          else b = o ^ (8'h11 * (i + 1));
          eprm[8*i +: 8] = b;
          send(b);
        end
        if (o < 8'h80) begin
          cnt = eprm[7:0] + 1;
          if (nh == 2) npl = ((o / 16) % 2 == 1) ? cnt : 0;
          else npl = (((o / 16) % 2 == 1) || ((o / 64) % 2 == 1)) ? 1 : 0;
        end
        for (int j = 0; j < npl; j++) begin
          send(o + j[7:0] + 8'd1);
          esum += (o + j + 1) % 256;
        end
        idle(4);
        check(ndesc == d0 + 1, "R2 one descriptor per frame", ndesc - d0, 1);
        check(c_op == o, "R2 opcode", c_op, o);
        check(c_np == nh[1:0] && c_params == eprm, "R2 header bytes", {c_np, c_params}, {nh[1:0], eprm});
        if (o < 8'h80) begin
          check(c_shift && c_flags == o[6:0], "R3 shift flags", {c_shift, c_flags}, {1'b1, o[6:0]});
          check(c_count == cnt, (nh == 2) ? "R4 byte count" : "R5 bit count", c_count, cnt);
          check(npay == p0 + npl && psum == s0 + esum, (nh == 2) ? "R4 payload" : "R5 payload",
                npay - p0, npl);
          if (npl > 0)
            check(nlast == l0 + 1 && last_idx == npay, "R8 last marker", nlast - l0, 1);
        end else begin
          check(!c_shift && c_flags == 0 && c_count == 0, "R3 control zero fields",
                {c_shift, c_flags, c_count}, 0);
        end
      end else begin
        idle(3);
        check(ndesc == d0 && err_flag, "R6 invalid opcode", {ndesc - d0, err_flag}, 1);
        do_reset();
      end
    end

    // R4 boundary: maximum length on a read-only byte shift
    d0 = ndesc; p0 = npay;
    send(8'h20); send(8'hFF); send(8'hFF); idle(3);
    check(c_count == 17'd65536 && npay == p0, "R4 max count", c_count, 17'd65536);

    // R4 little-endian order with payload, R8 last
    d0 = ndesc; p0 = npay; l0 = nlast;
    send(8'h11); send(8'h00); send(8'h01);
    for (int j = 0; j < 257; j++) send(j[7:0]);
    idle(3);
    check(c_count == 17'd257, "R4 low byte first", c_count, 257);
    check(npay == p0 + 257, "R4 payload length", npay - p0, 257);
    check(nlast == l0 + 1 && last_idx == npay && c_pdata == 8'h00, "R8 final byte marked",
          last_idx, npay);

    // R6 sticky flag and resync
    send(8'h00); idle(2);
    check(err_flag == 1, "R6 flag set", err_flag, 1);
    send(8'h14); send(8'h80); send(8'hA5); send(8'h3C); idle(3);
    check(c_op == 8'h80 && c_params == 24'h003CA5, "R6 resync after invalid", c_params, 24'h003CA5);
    check(err_flag == 1, "R6 flag sticky", err_flag, 1);
    do_reset();

    // R7 back to back
    d0 = ndesc;
    send(8'h87); send(8'h84); send(8'h85); idle(3);
    check(ndesc == d0 + 3 && c_op == 8'h85, "R7 back to back", ndesc - d0, 3);

    // R7 descriptor backpressure
    d0 = ndesc;
    desc_ready = 1'b0;
    send(8'h87);
    in_valid = 1'b1; in_data = 8'h84; #1;
    check(!in_ready && desc_valid && desc_opcode == 8'h87, "R7 stall on descriptor",
          {in_ready, desc_opcode}, 8'h87);
    @(negedge clk); @(negedge clk); #1;
    check(!in_ready && desc_valid && desc_opcode == 8'h87, "R7 descriptor held", desc_opcode, 8'h87);
    desc_ready = 1'b1;
    @(negedge clk); idle(3);
    check(ndesc == d0 + 2 && c_op == 8'h84, "R7 release", {ndesc - d0, c_op}, {32'd2, 8'h84});

    // R7 payload backpressure
    p0 = npay; l0 = nlast;
    pay_ready = 1'b0;
    send(8'h19); send(8'h01); send(8'h00); send(8'hAA);
    in_valid = 1'b1; in_data = 8'hBB; #1;
    check(!in_ready && pay_valid && pay_data == 8'hAA, "R7 stall on payload", pay_data, 8'hAA);
    @(negedge clk); #1;
    check(!in_ready && pay_data == 8'hAA && !pay_last, "R7 payload held", pay_data, 8'hAA);
    pay_ready = 1'b1;
    @(negedge clk); idle(3);
    check(npay == p0 + 2 && c_pdata == 8'hBB && nlast == l0 + 1, "R8 order after stall",
          c_pdata, 8'hBB);

    // R9 reset mid-frame
    send(8'h80); send(8'h12);
    do_reset();
    d0 = ndesc;
    send(8'h87); idle(3);
    check(ndesc == d0 + 1 && c_op == 8'h87 && c_np == 0, "R9 reset mid-frame", c_op, 8'h87);
    check(!err_flag, "R9 flag clear after reset", err_flag, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule